// File: doc/BRIEF.md
# Skewed Vector Bank Mapper

This block turns a vector access into a stream of bank locations for a memory built from `MODS` independent modules. The count `MODS` is a parameter and need not be a power of two; a prime such as 17 is the default. Element `i` of a vector with skew `d` and start offset `C` is stored in module `(d*i + C) mod MODS`. Inside that module it sits at row `base + floor((d*i + C) / MODS)`.

A request carries the length `N`, the skew `d`, the offset `C` and the base row. It is accepted in idle with a valid/ready handshake. A setup phase then runs with no divider. Two subtract-based units reduce `d` and `C` modulo `MODS`, and a subtract-based unit then forms `gcd(MODS, d)`. The block then pulses `cfg_done` for one cycle, together with a flag that says whether the access is conflict-free, meaning `MODS >= N * gcd(MODS, d)`. After that it emits one module/row pair per element under a valid/ready handshake, and `elem_last` marks the final element. Each element is produced from the previous one by an add with conditional subtract, and the row carries whenever the module index wraps.

The control FSM has five states. `IDLE` waits for a request. `DIV` waits for both reductions to finish. `GCD` waits for the gcd unit. `REPORT` is the single `cfg_done` cycle. `EMIT` streams the elements. The transitions are: IDLE to DIV when a request is accepted; DIV to GCD when both reductions are idle; GCD to REPORT when the gcd is done; REPORT to EMIT when `N > 0`, or REPORT to IDLE when `N = 0`; EMIT to IDLE on the handshake of the last element.

Top module: `svm_bank_mapper`

## Requirements
- R1: For element i (counting from 0), `elem_module` equals `(d*i + C) mod MODS` for any `MODS`, including values that are not a power of two.
- R2: For element i, `elem_offset` equals `(base + floor((d*i + C)/MODS)) mod 2^OFS_W`.
- R3: In the `cfg_done` cycle, `conflict_free` is 1 exactly when `MODS >= N * gcd(MODS, d)`, where `gcd(MODS, 0) = MODS`. The value then holds until the next request is accepted.
- R4: When `MODS` is a power of two and `d` is a multiple of `MODS`, every element maps to module `C mod MODS`, and for `N >= 2` `conflict_free` is 0.
- R5: `cfg_done` is high for exactly one cycle, and the first `elem_valid` follows in the next cycle.
- R6: While `elem_valid` is high and `elem_ready` is low, `elem_module`, `elem_offset` and `elem_last` hold their values, and the stream advances only on a handshake.
- R7: `elem_last` is high only together with element N-1. No element follows it.
- R8: `start_ready` is high only in IDLE. A `start_valid` held high with other field values during a stream has no effect on that stream.
- R9: A request with `N = 0` pulses `cfg_done` with `conflict_free = 1`, emits no element, and returns to IDLE.
- R10: After reset, `start_ready = 1`, `elem_valid = 0`, `cfg_done = 0` and `conflict_free = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Block idle, request accepted |
| start_len | input | LEN_W | Element count N |
| start_skew | input | SKEW_W | Skew d |
| start_ofs | input | SKEW_W | Start offset C |
| start_base | input | OFS_W | Base row within each module |
| cfg_done | output | 1 | One-cycle pulse when setup has finished |
| conflict_free | output | 1 | Access is conflict-free (valid from cfg_done) |
| elem_valid | output | 1 | Element location present |
| elem_ready | input | 1 | Consumer takes the element |
| elem_module | output | $clog2(MODS+1) | Module index of the element |
| elem_offset | output | OFS_W | Row within the module |
| elem_last | output | 1 | Marks element N-1 |

## Verification
The hardest case to reach from the ports is the conflict decision near its boundary. There `gcd(MODS, d)` is larger than 1, and `N * gcd` sits on either side of `MODS`. The bench reaches it by sweeping every skew from 0 to 35 against the prime `MODS` = 17, and every skew from 0 to 20 against a second instance with `MODS` = 8. Both sweeps use lengths on both sides of `MODS`, and for `MODS` = 8 the skews of 0, 8 and 16 place the whole vector in one module. Stalls on `elem_ready` and a request held high during streaming are mixed into the sweep, so that the handshake and the idle guard are exercised while the carry of the row is in flight.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
package svm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV,
        S_GCD,
        S_REPORT,
        S_EMIT
    } svm_state_e;
endpackage

// File: rtl/svm_divmod.sv
`timescale 1ns/1ps
// Iterative reduction by repeated subtraction: quotient and remainder of din / MODS.
module svm_divmod #(
    parameter int MODS = 17,
    parameter int W    = 8,
    parameter int MW   = $clog2(MODS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [W-1:0]  din,
    output logic          idle,
    output logic [MW-1:0] rem,
    output logic [W-1:0]  quo
);
    localparam logic [W-1:0] MOD_W = W'(MODS);

    logic         run;
    logic [W-1:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            acc <= '0;
            quo <= '0;
        end else if (go) begin
            run <= 1'b1;
            acc <= din;
            quo <= '0;
        end else if (run) begin
            if (acc >= MOD_W) begin
                acc <= acc - MOD_W;
                quo <= quo + 1'b1;
            end else begin
                run <= 1'b0;
            end
        end
    end

    assign idle = !run;
    assign rem  = MW'(acc);

    // R1: a finished reduction always leaves a remainder below the module count
    p_rem_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (acc < MOD_W));
endmodule

// File: rtl/svm_gcd.sv
`timescale 1ns/1ps
// Subtract-and-swap greatest common divisor of MODS and bin (bin < MODS).
module svm_gcd #(
    parameter int MODS = 17,
    parameter int MW   = $clog2(MODS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [MW-1:0] bin,
    output logic          idle,
    output logic [MW-1:0] g
);
    logic          run;
    logic [MW-1:0] a;
    logic [MW-1:0] b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            a   <= MW'(MODS);
            b   <= '0;
        end else if (go) begin
            run <= 1'b1;
            a   <= MW'(MODS);
            b   <= bin;
        end else if (run) begin
            if (b == '0) begin
                run <= 1'b0;
            end else if (a >= b) begin
                a <= a - b;
            end else begin
                a <= b;
                b <= a;
            end
        end
    end

    assign idle = !run;
    assign g    = a;

    // R3: the gcd produced must divide the module count
    p_gcd_divides_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> (a != '0 && (MODS % int'(a)) == 0));
endmodule

// File: rtl/svm_walker.sv
`timescale 1ns/1ps
// Incremental element stepper: module index by add with conditional subtract,
// row by adding the skew quotient plus a carry on wrap.
module svm_walker #(
    parameter int MODS  = 17,
    parameter int OFS_W = 12,
    parameter int MW    = $clog2(MODS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [MW-1:0]    r0,
    input  logic [OFS_W-1:0] q0,
    input  logic [MW-1:0]    step_r,
    input  logic [OFS_W-1:0] step_q,
    output logic [MW-1:0]    r,
    output logic [OFS_W-1:0] q
);
    localparam logic [MW:0] MOD_X = (MW + 1)'(MODS);

    logic [MW:0] sum;
    logic        wrap;

    assign sum  = {1'b0, r} + {1'b0, step_r};
    assign wrap = (sum >= MOD_X);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r <= '0;
            q <= '0;
        end else if (load) begin
            r <= r0;
            q <= q0;
        end else if (adv) begin
            r <= wrap ? MW'(sum - MOD_X) : MW'(sum);
            q <= q + step_q + (wrap ? OFS_W'(1) : OFS_W'(0));
        end
    end

    // R2: an advance whose module index went down must have carried into the row
    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && !load) && (r < $past(r)) |-> (q == $past(q) + $past(step_q) + OFS_W'(1)));
endmodule

// File: rtl/svm_bank_mapper.sv
`timescale 1ns/1ps
module svm_bank_mapper
    import svm_pkg::*;
#(
    parameter int MODS   = 17,
    parameter int LEN_W  = 6,
    parameter int SKEW_W = 8,
    parameter int OFS_W  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_valid,
    output logic                         start_ready,
    input  logic [LEN_W-1:0]             start_len,
    input  logic [SKEW_W-1:0]            start_skew,
    input  logic [SKEW_W-1:0]            start_ofs,
    input  logic [OFS_W-1:0]             start_base,
    output logic                         cfg_done,
    output logic                         conflict_free,
    output logic                         elem_valid,
    input  logic                         elem_ready,
    output logic [$clog2(MODS+1)-1:0]    elem_module,
    output logic [OFS_W-1:0]             elem_offset,
    output logic                         elem_last
);
    localparam int MW = $clog2(MODS + 1);
    localparam int PW = LEN_W + MW;
    localparam int NDIV = 2;   // index 0 reduces the skew, index 1 the start offset

    svm_state_e state_q, state_d;

    logic [LEN_W-1:0]  n_q;
    logic [LEN_W-1:0]  idx_q;
    logic [OFS_W-1:0]  base_q;
    logic              cf_q;

    logic              div_go, gcd_go, walk_adv, is_last, div_all_idle;
    logic [SKEW_W-1:0] dv_in   [NDIV];
    logic [SKEW_W-1:0] dv_quo  [NDIV];
    logic [MW-1:0]     dv_rem  [NDIV];
    logic              dv_idle [NDIV];
    logic              gcd_idle;
    logic [MW-1:0]     gcd_val;
    logic [PW-1:0]     need;
    logic [MW-1:0]     w_r;
    logic [OFS_W-1:0]  w_q;

    assign dv_in[0] = start_skew;
    assign dv_in[1] = start_ofs;

    for (genvar k = 0; k < NDIV; k++) begin : g_div
        svm_divmod #(.MODS(MODS), .W(SKEW_W), .MW(MW)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (div_go),
            .din  (dv_in[k]),
            .idle (dv_idle[k]),
            .rem  (dv_rem[k]),
            .quo  (dv_quo[k])
        );
    end

    svm_gcd #(.MODS(MODS), .MW(MW)) u_gcd (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (gcd_go),
        .bin  (dv_rem[0]),
        .idle (gcd_idle),
        .g    (gcd_val)
    );

    svm_walker #(.MODS(MODS), .OFS_W(OFS_W), .MW(MW)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gcd_go),
        .adv   (walk_adv),
        .r0    (dv_rem[1]),
        .q0    (base_q + OFS_W'(dv_quo[1])),
        .step_r(dv_rem[0]),
        .step_q(OFS_W'(dv_quo[0])),
        .r     (w_r),
        .q     (w_q)
    );

    assign div_all_idle = dv_idle[0] && dv_idle[1];
    assign is_last      = (idx_q == n_q - LEN_W'(1));
    assign need         = PW'(n_q) * PW'(gcd_val);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_valid)           state_d = S_DIV;
            S_DIV:    if (div_all_idle)          state_d = S_GCD;
            S_GCD:    if (gcd_idle)              state_d = S_REPORT;
            S_REPORT: state_d = (n_q == '0) ? S_IDLE : S_EMIT;
            S_EMIT:   if (elem_ready && is_last) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and unit controls
    always_comb begin
        start_ready = 1'b0;
        cfg_done    = 1'b0;
        elem_valid  = 1'b0;
        div_go      = 1'b0;
        gcd_go      = 1'b0;
        walk_adv    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                start_ready = 1'b1;
                div_go      = start_valid;
            end
            S_DIV:    gcd_go = div_all_idle;
            S_GCD:    ;
            S_REPORT: cfg_done = 1'b1;
            S_EMIT: begin
                elem_valid = 1'b1;
                walk_adv   = elem_ready && !is_last;
            end
            default: ;
        endcase
    end

    assign elem_module   = w_r;
    assign elem_offset   = w_q;
    assign elem_last     = elem_valid && is_last;
    assign conflict_free = cf_q;

    // request fields, element counter, conflict flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            idx_q  <= '0;
            base_q <= '0;
            cf_q   <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start_valid) begin
                n_q    <= start_len;
                base_q <= start_base;
            end
            if (state_q == S_GCD && gcd_idle)
                cf_q <= (PW'(MODS) >= need);
            if (state_q == S_REPORT)
                idx_q <= '0;
            else if (walk_adv)
                idx_q <= idx_q + LEN_W'(1);
        end
    end

    // R1: emitted module index is always a legal module
    p_module_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> (elem_module < MW'(MODS)));

    // R5: the first element of a stream follows the setup pulse directly
    p_done_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(elem_valid) |-> $past(cfg_done));

    // R6: a stalled element holds its contents
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && !elem_ready |=> elem_valid && $stable(elem_module)
                                      && $stable(elem_offset) && $stable(elem_last));

    // R7: the last marker travels only with a valid element and ends the stream
    p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        elem_last |-> elem_valid);
    p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        elem_last && elem_ready |=> !elem_valid);

    // R8: request acceptance and streaming never overlap
    p_idle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !elem_valid && !cfg_done);
endmodule

// File: tb/tb_svm_bank_mapper.sv
`timescale 1ns/1ps
module tb_svm_bank_mapper;
    localparam int LEN_W = 6, SKEW_W = 8, OFS_W = 12;
    localparam int MA = 17, MB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              start_valid = 1'b0;
    int                sel = 0;
    logic [LEN_W-1:0]  s_len = '0;
    logic [SKEW_W-1:0] s_skew = '0, s_ofs = '0;
    logic [OFS_W-1:0]  s_base = '0;
    logic              e_ready = 1'b0;

    logic a_sr, a_done, a_cf, a_v, a_last;
    logic [$clog2(MA+1)-1:0] a_mod;
    logic [OFS_W-1:0] a_ofs;
    logic b_sr, b_done, b_cf, b_v, b_last;
    logic [$clog2(MB+1)-1:0] b_mod;
    logic [OFS_W-1:0] b_ofs;

    svm_bank_mapper #(.MODS(MA), .LEN_W(LEN_W), .SKEW_W(SKEW_W), .OFS_W(OFS_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid && sel == 0), .start_ready(a_sr),
        .start_len(s_len), .start_skew(s_skew), .start_ofs(s_ofs), .start_base(s_base),
        .cfg_done(a_done), .conflict_free(a_cf), .elem_valid(a_v), .elem_ready(e_ready),
        .elem_module(a_mod), .elem_offset(a_ofs), .elem_last(a_last));

    svm_bank_mapper #(.MODS(MB), .LEN_W(LEN_W), .SKEW_W(SKEW_W), .OFS_W(OFS_W)) dut_p2 (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid && sel == 1), .start_ready(b_sr),
        .start_len(s_len), .start_skew(s_skew), .start_ofs(s_ofs), .start_base(s_base),
        .cfg_done(b_done), .conflict_free(b_cf), .elem_valid(b_v), .elem_ready(e_ready),
        .elem_module(b_mod), .elem_offset(b_ofs), .elem_last(b_last));

    // selected instance
    logic o_sr, o_done, o_cf, o_v, o_last;
    int   o_mod, o_ofs;
    always_comb begin
        if (sel == 0) begin
            o_sr = a_sr; o_done = a_done; o_cf = a_cf; o_v = a_v; o_last = a_last;
            o_mod = int'(a_mod); o_ofs = int'(a_ofs);
        end else begin
            o_sr = b_sr; o_done = b_done; o_cf = b_cf; o_v = b_v; o_last = b_last;
            o_mod = int'(b_mod); o_ofs = int'(b_ofs);
        end
    end

    int  n_checks = 0, n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int ref_gcd(input int x, input int y);
        int p = x, q = y, t;
        while (q != 0) begin t = p % q; p = q; q = t; end
        return p;
    endfunction

    task automatic run_case(input int which, input int d, input int c, input int n,
                            input int b, input bit stall, input bit hold);
        int m   = (which == 0) ? MA : MB;
        int g   = ref_gcd(m, d % m);
        bit ecf = (m >= n * g);
        int i   = 0;
        int tick = 0;
        int wait_n = 0;
        bit v;
        sel         = which;
        s_len       = LEN_W'(n);
        s_skew      = SKEW_W'(d);
        s_ofs       = SKEW_W'(c);
        s_base      = OFS_W'(b);
        start_valid = 1'b1;
        e_ready     = 1'b0;
        #0.1;
        chk(o_sr == 1'b1, "R8 idle ready", int'(o_sr), 1);
        @(posedge clk); @(negedge clk);
        if (hold) begin
            s_len  = LEN_W'(n + 1);
            s_skew = SKEW_W'(d + 3);
            s_ofs  = SKEW_W'(c + 1);
            s_base = OFS_W'(b + 7);
        end else begin
            start_valid = 1'b0;
        end
        while (!o_done && wait_n < 200) begin
            chk(o_v == 1'b0 && o_sr == 1'b0, "R5 no element before cfg_done", int'(o_v), 0);
            @(negedge clk); wait_n++;
        end
        chk(o_done == 1'b1, "R5 cfg_done seen", int'(o_done), 1);
        chk(o_cf == ecf, (m == MB && d % m == 0 && n >= 2) ? "R4 conflict flag" : "R3 conflict flag",
            int'(o_cf), int'(ecf));
        if (n == 0) begin
            start_valid = 1'b0;
            @(negedge clk);
            chk(o_v == 1'b0 && o_sr == 1'b1, "R9 empty access returns idle", int'(o_v), 0);
            chk(o_cf == 1'b1, "R9 empty access conflict-free", int'(o_cf), 1);
            return;
        end
        @(negedge clk);
        chk(o_v == 1'b1, "R5 first element right after cfg_done", int'(o_v), 1);
        wait_n = 0;
        while (i < n && wait_n < 400) begin
            e_ready = stall ? (((i + tick) % 3) != 0) : 1'b1;
            #0.1;
            v = o_v;
            if (v) begin
                chk(o_mod == (d * i + c) % m,
                    (m == MB && d % m == 0) ? "R4 single module" : "R1 module index",
                    o_mod, (d * i + c) % m);
                chk(o_ofs == (b + (d * i + c) / m) % (1 << OFS_W), "R2 row offset",
                    o_ofs, (b + (d * i + c) / m) % (1 << OFS_W));
                chk(o_last == (i == n - 1), "R7 last flag", int'(o_last), int'(i == n - 1));
                chk(o_sr == 1'b0, "R8 busy during stream", int'(o_sr), 0);
                if (e_ready && i == n - 1) start_valid = 1'b0;
            end else begin
                chk(1'b0, "R6 valid dropped mid-stream", 0, 1);
            end
            @(posedge clk);
            if (v && e_ready) i++;
            tick++; wait_n++;
            @(negedge clk);
        end
        e_ready = 1'b0;
        chk(i == n, "R6 all elements delivered", i, n);
        chk(o_v == 1'b0 && o_sr == 1'b1, "R7 no element after last", int'(o_v), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(o_sr == 1'b1 && a_v == 1'b0 && b_v == 1'b0, "R10 reset ready/valid", int'(o_sr), 1);
        chk(a_done == 1'b0 && a_cf == 1'b0 && b_cf == 1'b0, "R10 reset done/flag", int'(a_cf), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(a_sr == 1'b1 && b_sr == 1'b1, "R10 ready after reset", int'(a_sr), 1);
        // prime module count sweep
        for (int d = 0; d < 36; d++) begin
            foreach (cs_a[k]) begin
                foreach (ns_a[j]) begin
                    run_case(0, d, cs_a[k], ns_a[j], (d * 3 + cs_a[k]) % 4096, d[0],
                             (d == 9 && j == 2));
                end
            end
        end
        // power-of-two module count sweep
        for (int d = 0; d < 21; d++) begin
            foreach (cs_b[k]) begin
                foreach (ns_b[j]) begin
                    run_case(1, d, cs_b[k], ns_b[j], 4090 - d, d[1], (d == 8 && j == 1));
                end
            end
        end
        run_case(0, 5, 2, 0, 11, 1'b0, 1'b0);
        run_case(1, 16, 3, 0, 11, 1'b0, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    int cs_a[4] = '{0, 7, 16, 30};
    int ns_a[4] = '{1, 5, 17, 18};
    int cs_b[4] = '{0, 3, 9, 12};
    int ns_b[5] = '{1, 4, 8, 9, 0};

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule